// File: doc/BRIEF.md
# Codec Serial Link Frame Engine

This block runs a fixed-rate, bidirectional, time-slotted serial PCM link to an external audio codec. The codec supplies the bit clock. Each frame is 256 bit clocks long. It opens with a 16-bit tag slot and then carries twelve 20-bit data slots in each direction. On the transmit side the engine takes one parallel word per slot, each with a valid flag. At each frame boundary it captures those words and shifts them out most-significant bit first. On the receive side it rebuilds each incoming slot into a parallel word. A word is reported only when the codec's incoming tag marks that slot as valid.

The engine also drives the codec control pins. A cold-reset request pulls the active-low codec reset pin low at once. A warm-reset request raises the frame sync output at once. Neither pin waits for a bit-clock edge, so both work while the codec has stopped its clock. While either request is active, or while the synchronous reset is high, the frame engine is held idle. When the hold ends, the first frame starts on the next rising bit-clock edge.

Top module: `aclink_engine`

## Requirements
- R1: A frame lasts exactly 256 bit clocks. `sync` is high for the first 16 bit periods of each frame, which is the tag slot, and low for the remaining 240.
- R2: When every hold condition is released, the rising edge that follows starts position 0 of a frame. On that edge `sync` goes high.
- R3: The outgoing tag slot is sent most-significant bit first and is built as follows. Bit 15 is the OR of all `tx_valid` bits. Bit 14-i equals `tx_valid[i]`, which belongs to slot i+1, for i from 0 to 11. Bits 2..0 are zero.
- R4: Outgoing data slot k (1..12) carries `tx_data[20*(k-1) +: 20]`, most-significant bit first. It occupies frame positions 16+20*(k-1) through 16+20*k-1. `sdata_out` changes only on rising bit-clock edges.
- R5: Every bit of an outgoing data slot whose `tx_valid` bit is clear is sent as 0.
- R6: The engine captures `tx_valid` and `tx_data` only on the rising edge that starts a frame. Changes later in the frame do not affect it. `tx_take` equals the captured `tx_valid` for the first bit period of the frame and is zero at all other times.
- R7: `sdata_in` is sampled on the falling bit-clock edge, and words are assembled most-significant bit first. One bit period after the rising edge that ends the last bit of slot k, `rx_valid` pulses for one period, with `rx_slot` = k and `rx_word` holding the slot's 20 bits.
- R8: A received slot k is reported only when bit 14-(k-1) of the incoming tag is set. Slots whose tag bit is clear produce no `rx_valid` pulse.
- R9: While `cold_rst_req` is high, `codec_rst_n` is low without waiting for any clock edge. The engine is held: `sdata_out` and `sync` stay low.
- R10: While `warm_rst_req` is high, `sync` is high without needing the bit clock. The engine is held with `sdata_out` low.
- R11: While `rst` is high on a rising edge, the engine returns to idle. `sdata_out`, `sync`, `tx_take` and `rx_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock supplied by the codec |
| rst | input | 1 | Synchronous active-high reset in the bit-clock domain |
| cold_rst_req | input | 1 | Request to hold the codec in cold reset |
| warm_rst_req | input | 1 | Request to send a warm-reset wake-up on the sync pin |
| codec_rst_n | output | 1 | Active-low cold reset pin to the codec |
| sync | output | 1 | Frame sync pin to the codec |
| sdata_out | output | 1 | Serial data toward the codec |
| sdata_in | input | 1 | Serial data from the codec |
| tx_valid | input | 12 | Per-slot valid flags for outgoing slots 1..12 |
| tx_data | input | 240 | Outgoing slot words, slot k at bits 20*(k-1) +: 20 |
| tx_take | output | 12 | One-period pulse showing which slot words were captured |
| rx_valid | output | 1 | One-period pulse: a received slot word is present |
| rx_slot | output | 4 | Index 1..12 of the received slot |
| rx_word | output | 20 | Received slot word |

## Verification
Frame position p is defined as the bit period that follows the rising edge that moved the engine to p. In that period, `sync` and `sdata_out` already show position p. `tx_take` is due in the period of position 0. A received word is due one period after the last bit of its slot, so slot 12 lands in position 0 of the next frame. The bench drives serial input one nanosecond after each rising edge and inverts it just after the falling edge, so any sampling point other than the falling edge reads the wrong bit. All outputs are compared four nanoseconds after the rising edge. The cold-reset and warm-reset pins are checked within a nanosecond of the request, and again while the bit clock is stopped.

// File: rtl/aclink_pkg.sv
`timescale 1ns/1ps
package aclink_pkg;
    localparam int SLOTS      = 12;
    localparam int SLOT_W     = 20;
    localparam int TAG_W      = 16;
    localparam int FRAME_BITS = TAG_W + SLOTS * SLOT_W;
    localparam int DATA_W     = SLOTS * SLOT_W;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int SLOT_IDX_W = $clog2(SLOTS + 1);
    localparam int BIT_W      = $clog2((TAG_W > SLOT_W) ? TAG_W : SLOT_W);

    typedef logic [POS_W-1:0]      pos_t;
    typedef logic [SLOT_W-1:0]     word_t;
    typedef logic [TAG_W-1:0]      tag_t;
    typedef logic [SLOT_IDX_W-1:0] slot_t;

    localparam pos_t LAST_POS = pos_t'(FRAME_BITS - 1);

    // Where a frame position falls: tag slot or data slot, and which bit.
    typedef struct packed {
        logic                in_tag;
        logic                slot_end;
        slot_t               slot;
        logic [BIT_W-1:0]    bit_idx;
    } pos_info_t;

    // Captured outgoing frame contents.
    typedef struct packed {
        tag_t                           tag;
        logic [SLOTS-1:0][SLOT_W-1:0]   words;
    } tx_frame_t;

    function automatic pos_info_t decode_pos(pos_t p);
        pos_info_t info;
        int        off;
        info = '0;
        if (int'(p) < TAG_W) begin
            info.in_tag   = 1'b1;
            info.slot_end = (int'(p) == TAG_W - 1);
            info.bit_idx  = BIT_W'(TAG_W - 1 - int'(p));
        end else begin
            off           = int'(p) - TAG_W;
            info.slot     = slot_t'(off / SLOT_W + 1);
            info.bit_idx  = BIT_W'(SLOT_W - 1 - (off % SLOT_W));
            info.slot_end = ((off % SLOT_W) == SLOT_W - 1);
        end
        return info;
    endfunction

    function automatic tag_t make_tag(logic [SLOTS-1:0] v);
        tag_t t;
        t = '0;
        t[TAG_W-1] = |v;
        for (int i = 0; i < SLOTS; i++) begin
            t[TAG_W-2-i] = v[i];
        end
        return t;
    endfunction

    // Tag bit owned by data slot s (1..SLOTS).
    function automatic logic slot_flag(tag_t t, slot_t s);
        return t[TAG_W-1-int'(s)];
    endfunction

    function automatic logic frame_bit(tx_frame_t f, pos_t p);
        pos_info_t info;
        info = decode_pos(p);
        if (info.in_tag) begin
            return f.tag[info.bit_idx];
        end
        return f.words[int'(info.slot) - 1][info.bit_idx];
    endfunction
endpackage

// File: rtl/aclink_timing.sv
`timescale 1ns/1ps
module aclink_timing
    import aclink_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hold,
    output pos_t pos,
    output pos_t pos_nxt,
    output logic run,
    output logic start,
    output logic sync_q
);
    logic idle;

    assign idle    = rst || hold;
    assign start   = !idle && (!run || (pos == LAST_POS));
    assign pos_nxt = start ? '0 : pos + pos_t'(1);

    always_ff @(posedge clk) begin
        if (idle) begin
            run    <= 1'b0;
            pos    <= '0;
            sync_q <= 1'b0;
        end else begin
            run    <= 1'b1;
            pos    <= pos_nxt;
            sync_q <= (pos_nxt < pos_t'(TAG_W));
        end
    end

    AST_SYNC_OPENS_FRAME: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_q) |-> (pos == '0 && run)) else $error("sync rise off frame start"); // R1

    AST_HOLD_PARKS: assert property (@(posedge clk) disable iff (rst)
        hold |=> (pos == '0 && !run && !sync_q)) else $error("hold did not park counter"); // R9
endmodule

// File: rtl/aclink_tx.sv
`timescale 1ns/1ps
module aclink_tx
    import aclink_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              start,
    input  pos_t              pos_nxt,
    input  logic [SLOTS-1:0]  tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdata_q,
    output logic [SLOTS-1:0]  tx_take
);
    tx_frame_t frame_q;
    tx_frame_t frame_d;

    always_comb begin
        frame_d.tag = make_tag(tx_valid);
        for (int i = 0; i < SLOTS; i++) begin
            frame_d.words[i] = tx_valid[i] ? tx_data[i*SLOT_W +: SLOT_W] : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            frame_q <= '0;
            sdata_q <= 1'b0;
            tx_take <= '0;
        end else if (start) begin
            frame_q <= frame_d;
            sdata_q <= frame_d.tag[TAG_W-1];
            tx_take <= tx_valid;
        end else begin
            sdata_q <= frame_bit(frame_q, pos_nxt);
            tx_take <= '0;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_zero_chk
        AST_IDLE_SLOT_ZERO: assert property (@(posedge clk) disable iff (rst)
            !frame_q.tag[TAG_W-2-g] |-> (frame_q.words[g] == '0)) else $error("unflagged slot not zero"); // R5
    end

    AST_TAKE_MARKS_FRAME: assert property (@(posedge clk) disable iff (rst)
        (|tx_take) |-> frame_q.tag[TAG_W-1]) else $error("take without valid frame"); // R6
endmodule

// File: rtl/aclink_rx.sv
`timescale 1ns/1ps
module aclink_rx
    import aclink_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  hold,
    input  logic  run,
    input  pos_t  pos,
    input  logic  sdata_in,
    output logic  rx_valid,
    output slot_t rx_slot,
    output word_t rx_word
);
    logic      din_q;
    tag_t      tag_q;
    word_t     shift_q;
    pos_info_t info;

    assign info = decode_pos(pos);

    // Capture in the middle of the bit, on the falling edge.
    always_ff @(negedge clk) begin
        din_q <= sdata_in;
    end

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            tag_q    <= '0;
            shift_q  <= '0;
            rx_valid <= 1'b0;
            rx_slot  <= '0;
            rx_word  <= '0;
        end else if (run) begin
            if (info.in_tag) begin
                tag_q    <= {tag_q[TAG_W-2:0], din_q};
                rx_valid <= 1'b0;
            end else begin
                shift_q  <= {shift_q[SLOT_W-2:0], din_q};
                rx_valid <= info.slot_end && slot_flag(tag_q, info.slot);
                if (info.slot_end) begin
                    rx_slot <= info.slot;
                    rx_word <= {shift_q[SLOT_W-2:0], din_q};
                end
            end
        end else begin
            rx_valid <= 1'b0;
        end
    end

    AST_RX_SLOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (rx_slot >= slot_t'(1) && rx_slot <= slot_t'(SLOTS))) else $error("bad rx slot"); // R7

    AST_RX_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(run)) else $error("rx word while idle"); // R11
endmodule

// File: rtl/aclink_engine.sv
`timescale 1ns/1ps
module aclink_engine
    import aclink_pkg::*;
(
    input  logic              bit_clk,
    input  logic              rst,
    input  logic              cold_rst_req,
    input  logic              warm_rst_req,
    output logic              codec_rst_n,
    output logic              sync,
    output logic              sdata_out,
    input  logic              sdata_in,
    input  logic [SLOTS-1:0]  tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic [SLOTS-1:0]  tx_take,
    output logic              rx_valid,
    output slot_t             rx_slot,
    output word_t             rx_word
);
    logic hold;
    pos_t pos;
    pos_t pos_nxt;
    logic run;
    logic start;
    logic sync_q;

    assign hold = cold_rst_req || warm_rst_req;

    // Codec control pins respond without any clock edge.
    assign codec_rst_n = !cold_rst_req;
    assign sync        = sync_q || warm_rst_req;

    aclink_timing u_timing (
        .clk     (bit_clk),
        .rst     (rst),
        .hold    (hold),
        .pos     (pos),
        .pos_nxt (pos_nxt),
        .run     (run),
        .start   (start),
        .sync_q  (sync_q)
    );

    aclink_tx u_tx (
        .clk      (bit_clk),
        .rst      (rst),
        .hold     (hold),
        .start    (start),
        .pos_nxt  (pos_nxt),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .sdata_q  (sdata_out),
        .tx_take  (tx_take)
    );

    aclink_rx u_rx (
        .clk      (bit_clk),
        .rst      (rst),
        .hold     (hold),
        .run      (run),
        .pos      (pos),
        .sdata_in (sdata_in),
        .rx_valid (rx_valid),
        .rx_slot  (rx_slot),
        .rx_word  (rx_word)
    );

    AST_COLD_QUIET: assert property (@(posedge bit_clk) disable iff (rst)
        cold_rst_req |=> (!sdata_out && !sync_q)) else $error("active during cold reset"); // R9

    AST_TAKE_IN_TAG: assert property (@(posedge bit_clk) disable iff (rst)
        (|tx_take) |-> sync) else $error("take outside tag slot"); // R6
endmodule

// File: tb/aclink_engine_bench.sv
`timescale 1ns/1ps
module aclink_engine_bench;
    logic         bit_clk = 1'b0;
    logic         clk_run = 1'b1;
    logic         rst = 1'b1;
    logic         cold_rst_req = 1'b0;
    logic         warm_rst_req = 1'b0;
    logic         sdata_in = 1'b0;
    logic [11:0]  tx_valid = '0;
    logic [239:0] tx_data = '0;
    logic         codec_rst_n, sync, sdata_out, rx_valid;
    logic [11:0]  tx_take;
    logic [3:0]   rx_slot;
    logic [19:0]  rx_word;

    aclink_engine u_aclink_engine (
        .bit_clk(bit_clk), .rst(rst), .cold_rst_req(cold_rst_req), .warm_rst_req(warm_rst_req),
        .codec_rst_n(codec_rst_n), .sync(sync), .sdata_out(sdata_out), .sdata_in(sdata_in),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_take(tx_take),
        .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_word(rx_word)
    );

    initial forever begin
        #2.5;
        if (clk_run) bit_clk = ~bit_clk;
    end

    int n_checks = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] build_tx(logic [11:0] v, logic [239:0] d);
        logic [255:0] f = '0;
        f[255] = |v;
        for (int i = 0; i < 12; i++) begin
            f[254-i] = v[i];
            if (v[i]) f[239-20*i -: 20] = d[20*i +: 20];
        end
        return f;
    endfunction

    function automatic logic [255:0] build_rx(logic [15:0] t, logic [239:0] w);
        logic [255:0] f;
        f[255:240] = t;
        for (int i = 0; i < 12; i++) f[239-20*i -: 20] = w[20*i +: 20];
        return f;
    endfunction

    function automatic logic [239:0] pat(int seed);
        logic [239:0] r;
        for (int i = 0; i < 12; i++) r[20*i +: 20] = 20'(seed * 40503 + i * 7919 + 32'h10101);
        return r;
    endfunction

    // Scoreboard state
    logic [23:0]  exp_q[$];
    logic [255:0] cur_tx = '0, cur_rx = '0, pend_tx = '0, pend_rx = '0;
    logic [11:0]  cur_valid = '0, pend_valid = '0;
    logic [15:0]  pend_tag = '0;
    logic [239:0] pend_words = '0;
    int pos = 0;
    int since = 0;
    bit seen = 0, prev_sync = 0, mon_en = 0;
    bit sync_bad = 0, tag_bad = 0, zero_bad = 0, data_bad = 0;

    // Driver: sets the inputs and the expectation for the next frame.
    task automatic push_frame(input logic [11:0] v, input logic [239:0] d,
                              input logic [15:0] rtag, input logic [239:0] rw);
        tx_valid   = v;
        tx_data    = d;
        pend_valid = v;
        pend_tx    = build_tx(v, d);
        pend_rx    = build_rx(rtag, rw);
        pend_tag   = rtag;
        pend_words = rw;
    endtask

    task automatic wait_pos(input int n);
        forever begin
            @(posedge bit_clk);
            #2;
            if (seen && pos == n) break;
        end
    endtask

    // Codec model and monitor
    always begin
        @(posedge bit_clk);
        #1;
        if (mon_en) begin
            since++;
            if (sync && !prev_sync) begin
                if (seen) check(since == 256, "R1", "frame period", 64'(since), 64'd256);
                seen = 1; since = 0; pos = 0;
                cur_tx = pend_tx; cur_rx = pend_rx; cur_valid = pend_valid;
                for (int s = 1; s <= 12; s++)
                    if (pend_tag[15-s]) exp_q.push_back({4'(s), pend_words[20*(s-1) +: 20]});
            end else begin
                pos++;
            end
            prev_sync = sync;
            if (seen && pos < 256) sdata_in = cur_rx[255-pos];
        end
        #2.5;
        sdata_in = ~sdata_in;
        #0.5;
        if (mon_en && seen && pos < 256) begin
            if (sync !== (pos < 16)) sync_bad = 1;
            if (sdata_out !== cur_tx[255-pos]) begin
                if (pos < 16) tag_bad = 1;
                else if (!cur_valid[(pos-16)/20]) zero_bad = 1;
                else data_bad = 1;
            end
            if (pos == 0) check(tx_take == cur_valid, "R6", "take pulse", 64'(tx_take), 64'(cur_valid));
            else if (tx_take != 0) check(0, "R6", "take outside start", 64'(tx_take), 64'd0);
            if (rx_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R8", "unflagged rx word", {40'd0, rx_slot, rx_word}, 64'd0);
                end else begin
                    logic [23:0] item;
                    item = exp_q.pop_front();
                    check({rx_slot, rx_word} == item, "R7", "rx slot/word", {40'd0, rx_slot, rx_word}, {40'd0, item});
                end
            end
            if (pos == 255) begin
                check(!sync_bad, "R1", "sync shape", 64'(sync_bad), 64'd0);
                check(!tag_bad,  "R3", "tag bits",   64'(tag_bad),  64'd0);
                check(!zero_bad, "R5", "idle slot zero", 64'(zero_bad), 64'd0);
                check(!data_bad, "R4", "slot data",  64'(data_bad), 64'd0);
                sync_bad = 0; tag_bad = 0; zero_bad = 0; data_bad = 0;
            end
        end
    end

    initial begin
        #(200000 * 5);
        check(0, "R1", "watchdog expired", 64'd0, 64'd1);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit bad;
        logic [239:0] d;
        tx_valid = '1;
        tx_data  = pat(3);
        repeat (4) @(posedge bit_clk);
        #4;
        check(sdata_out == 0 && sync == 0, "R11", "idle pins in reset", {sdata_out, sync}, 64'd0);
        check(rx_valid == 0 && tx_take == 0, "R11", "idle strobes in reset", {rx_valid, tx_take}, 64'd0);
        check(codec_rst_n == 1, "R9", "reset pin idle", 64'(codec_rst_n), 64'd1);

        // Cold reset: pin falls with no clock edge, engine stays parked.
        @(posedge bit_clk); #1 cold_rst_req = 1;
        #1 check(codec_rst_n == 0, "R9", "cold pin asynchronous", 64'(codec_rst_n), 64'd0);
        @(posedge bit_clk); #1 rst = 0;
        bad = 0;
        repeat (6) begin
            @(posedge bit_clk); #4;
            if (sdata_out !== 0 || sync !== 0) bad = 1;
        end
        check(!bad, "R9", "held during cold reset", 64'(bad), 64'd0);

        // Warm reset: sync rises at once, even with the clock stopped.
        warm_rst_req = 1;
        cold_rst_req = 0;
        #1 check(sync == 1, "R10", "sync asynchronous", 64'(sync), 64'd1);
        check(codec_rst_n == 1, "R9", "cold pin released", 64'(codec_rst_n), 64'd1);
        clk_run = 0;
        #20;
        check(sync == 1 && sdata_out == 0, "R10", "sync without clock", {sync, sdata_out}, 64'h2);
        clk_run = 1;
        bad = 0;
        repeat (4) begin
            @(posedge bit_clk); #4;
            if (sdata_out !== 0 || sync !== 1) bad = 1;
        end
        check(!bad, "R10", "held during warm reset", 64'(bad), 64'd0);

        @(posedge bit_clk); #1 rst = 1; warm_rst_req = 0;
        repeat (2) @(posedge bit_clk);
        #4 check(sync == 0 && sdata_out == 0, "R11", "quiet after warm", {sync, sdata_out}, 64'd0);

        // Frame A: all slots valid, all incoming slots flagged.
        push_frame(12'hFFF, pat(5), 16'hFFF8, pat(11));
        mon_en = 1;
        @(posedge bit_clk); #1.5 rst = 0;
        @(posedge bit_clk); #4;
        check(sync == 1 && sdata_out == 1, "R2", "first frame on first edge", {sync, sdata_out}, 64'h3);

        // Frame B: slots 1, 5, 12 valid; unflagged words non-zero. Incoming 2 and 12.
        wait_pos(128);
        d = '1;
        d[0 +: 20] = 20'h80001; d[80 +: 20] = 20'h3C5A7; d[220 +: 20] = 20'hFFFFF;
        push_frame(12'h811, d, 16'hA008, pat(17));

        // Frame C: nothing valid either way.
        wait_pos(128);
        push_frame(12'h000, pat(23), 16'h0000, pat(29));

        // Frame D: alternate slots valid; incoming all flagged with edge words.
        wait_pos(128);
        d = pat(31);
        d[0 +: 20] = 20'h00001; d[40 +: 20] = 20'h80000;
        begin
            logic [239:0] w;
            w = pat(37);
            w[0 +: 20] = 20'hFFFFF; w[220 +: 20] = 20'h00001;
            push_frame(12'h555, d, 16'hFFF8, w);
        end

        // Frame E: no incoming flags, so the queue should drain.
        wait_pos(128);
        push_frame(12'h801, pat(41), 16'h8000, pat(43));

        wait_pos(255);
        repeat (3) @(posedge bit_clk);
        #4 check(exp_q.size() == 0, "R8", "all flagged words delivered", 64'(exp_q.size()), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule